// File: doc/BRIEF.md
# GPIO Port with Pin Overrides

An eight-pin general-purpose I/O port. Software sets four per-pin control words through a small register bus. These are the output latch, pullup enable, slew enable and direction. The port turns them into pad controls. Pad levels enter through a two-stage synchronizer and can be read back through the data offset. Output pins read back the latch value. Input pins read back the synchronized pad level.

Some pins can be claimed by an alternate function. Pin 0 belongs to the debug/mode function from reset onward. A sticky ownership flag records this claim. The flag is cleared either by a dedicated register write or by a release strobe from the debug side, and only reset sets it again. An oscillator-enable input claims pins 1 and 2. While a pin is claimed, its register bits have no effect on the pad: the owning function drives the pad, and a data read returns the pad level. The register bus is a plain single-cycle control path. Writes take effect at the clock edge where `bus_we` is high. Reads are combinational from the address. No data stream crosses this block, so it has no valid/ready handshake.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset, the data, pullup, slew and direction registers all read 0. Every pin not owned by an alternate function then has `pad_oe`, `pad_pu` and `pad_sre` low, and `dbg_own` is 1.
- R2: For a pin with no owner, direction bit 1 sets `pad_oe` high and drives the data latch bit on `pad_out`. Direction bit 0 sets `pad_oe` low.
- R3: A read of offset 0 returns, for each unowned pin, the latch bit if its direction bit is 1. If the direction bit is 0, it returns the pad level. A pad change becomes readable two clock edges later and not after one.
- R4: `pad_pu` equals the pullup bit only for unowned pins whose direction is 0. For output pins it is 0. Offset 1 reads back the value last written.
- R5: `pad_sre` equals the slew bit only for unowned pins whose direction is 1 (1 means slew limiting on). For input pins it is 0. Offset 2 reads back the value last written.
- R6: The offsets are 0 data, 1 pullup, 2 slew, 3 direction and 4 ownership release (write only). Reads of offsets 4 to 7 return 0.
- R7: While `dbg_own` is 1, pin 0 takes `pad_oe` from `dbg_oe` and `pad_out` from `dbg_out`, with `pad_pu` at 1 and `pad_sre` at 0, whatever its register bits hold.
- R8: `dbg_own` clears at the edge after a write to offset 4 with bit 0 set, or after `dbg_release` is high at an edge. A write to offset 4 with bit 0 clear leaves it set. Once clear it stays clear until reset, and pin 0 then follows its register bits.
- R9: While `osc_en` is 1, pins 1 and 2 take `pad_oe` from `osc_oe` and `pad_out` from `osc_out`, with `pad_pu` and `pad_sre` at 0. Their data, direction, pullup and slew bits have no effect on the pads.
- R10: For any owned pin, offset 0 returns the synchronized pad level whatever its direction bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output-driver enables |
| pad_pu | output | 8 | Pad pullup enables |
| pad_sre | output | 8 | Pad slew-limit enables |
| dbg_oe | input | 1 | Debug-side driver enable for pin 0 |
| dbg_out | input | 1 | Debug-side output value for pin 0 |
| dbg_release | input | 1 | Debug-side strobe that gives up pin 0 |
| dbg_own | output | 1 | High while pin 0 belongs to the debug function |
| osc_en | input | 1 | Oscillator claims pins 1 and 2 |
| osc_oe | input | 2 | Oscillator driver enables for pins 1 and 2 |
| osc_out | input | 2 | Oscillator output values for pins 1 and 2 |

## Verification
The bench builds the port with its defaults: eight pins, the oscillator claim on pins 1 and 2, and two synchronizer stages. With these values all three ownership variants of the pin mux are present side by side. These are the debug pin, the oscillator pair and the plain pins. Random register contents can therefore meet every combination of claim, direction, pullup and slew on one bus. The two-stage depth puts the one-edge and two-edge read checks on exact cycles. Re-applying reset covers both ways the debug claim can be released.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int unsigned GP_AW = 3;

  typedef enum logic [GP_AW-1:0] {
    OFS_DATA = 3'd0,
    OFS_PULL = 3'd1,
    OFS_SLEW = 3'd2,
    OFS_DIR  = 3'd3,
    OFS_OWN  = 3'd4
  } gp_ofs_e;
endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int unsigned N      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar p = 0; p < N; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[p]};
    end
    assign q[p] = chain[STAGES-1];
  end
endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GP_AW-1:0] addr,
  input  logic             we,
  input  logic [N-1:0]     wdata,
  input  logic             dbg_release,
  input  logic [N-1:0]     lvl,
  input  logic [N-1:0]     owned,
  output logic [N-1:0]     dat_q,
  output logic [N-1:0]     pu_q,
  output logic [N-1:0]     sre_q,
  output logic [N-1:0]     dir_q,
  output logic             dbg_own,
  output logic [N-1:0]     rdata
);
  logic [N-1:0] rd_pin;
  logic         sw_rel;

  assign sw_rel = we && (addr == OFS_OWN) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q   <= '0;
      pu_q    <= '0;
      sre_q   <= '0;
      dir_q   <= '0;
      dbg_own <= 1'b1;
    end else begin
      if (we) begin
        case (addr)
          OFS_DATA: dat_q <= wdata;
          OFS_PULL: pu_q  <= wdata;
          OFS_SLEW: sre_q <= wdata;
          OFS_DIR:  dir_q <= wdata;
          default:  ;
        endcase
      end
      if (sw_rel || dbg_release) dbg_own <= 1'b0;
    end
  end

  // Owned pins ignore direction and show the pad level.
  assign rd_pin = (dat_q & dir_q & ~owned) | (lvl & (~dir_q | owned));

  always_comb begin
    case (addr)
      OFS_DATA: rdata = rd_pin;
      OFS_PULL: rdata = pu_q;
      OFS_SLEW: rdata = sre_q;
      OFS_DIR:  rdata = dir_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_ovr_padmux.sv
module gpio_ovr_padmux #(
  parameter int unsigned N        = 8,
  parameter int unsigned OSC_BASE = 1,
  parameter int unsigned OSC_W    = 2
) (
  input  logic [N-1:0]     dat_q,
  input  logic [N-1:0]     pu_q,
  input  logic [N-1:0]     sre_q,
  input  logic [N-1:0]     dir_q,
  input  logic             dbg_own,
  input  logic             dbg_oe,
  input  logic             dbg_out,
  input  logic             osc_en,
  input  logic [OSC_W-1:0] osc_oe,
  input  logic [OSC_W-1:0] osc_out,
  output logic [N-1:0]     owned,
  output logic [N-1:0]     pad_out,
  output logic [N-1:0]     pad_oe,
  output logic [N-1:0]     pad_pu,
  output logic [N-1:0]     pad_sre
);
  for (genvar p = 0; p < N; p++) begin : g_pin
    logic gp_oe, gp_out, gp_pu, gp_sre;
    assign gp_oe  = dir_q[p];
    assign gp_out = dat_q[p];
    assign gp_pu  = pu_q[p] & ~dir_q[p];
    assign gp_sre = sre_q[p] & dir_q[p];

    if (p == 0) begin : g_dbg
      assign owned[p]   = dbg_own;
      assign pad_oe[p]  = dbg_own ? dbg_oe  : gp_oe;
      assign pad_out[p] = dbg_own ? dbg_out : gp_out;
      assign pad_pu[p]  = dbg_own ? 1'b1    : gp_pu;
      assign pad_sre[p] = dbg_own ? 1'b0    : gp_sre;
    end else if (p >= OSC_BASE && p < OSC_BASE + OSC_W) begin : g_osc
      assign owned[p]   = osc_en;
      assign pad_oe[p]  = osc_en ? osc_oe[p-OSC_BASE]  : gp_oe;
      assign pad_out[p] = osc_en ? osc_out[p-OSC_BASE] : gp_out;
      assign pad_pu[p]  = osc_en ? 1'b0 : gp_pu;
      assign pad_sre[p] = osc_en ? 1'b0 : gp_sre;
    end else begin : g_plain
      assign owned[p]   = 1'b0;
      assign pad_oe[p]  = gp_oe;
      assign pad_out[p] = gp_out;
      assign pad_pu[p]  = gp_pu;
      assign pad_sre[p] = gp_sre;
    end
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned N           = 8,
  parameter int unsigned OSC_BASE    = 1,
  parameter int unsigned OSC_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GP_AW-1:0] bus_addr,
  input  logic             bus_we,
  input  logic [N-1:0]     bus_wdata,
  output logic [N-1:0]     bus_rdata,
  input  logic [N-1:0]     pad_in,
  output logic [N-1:0]     pad_out,
  output logic [N-1:0]     pad_oe,
  output logic [N-1:0]     pad_pu,
  output logic [N-1:0]     pad_sre,
  input  logic             dbg_oe,
  input  logic             dbg_out,
  input  logic             dbg_release,
  output logic             dbg_own,
  input  logic             osc_en,
  input  logic [OSC_W-1:0] osc_oe,
  input  logic [OSC_W-1:0] osc_out
);
  logic [N-1:0] lvl, owned, dat_q, pu_q, sre_q, dir_q;

  gpio_ovr_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl)
  );

  gpio_ovr_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
    .wdata(bus_wdata), .dbg_release(dbg_release), .lvl(lvl),
    .owned(owned), .dat_q(dat_q), .pu_q(pu_q), .sre_q(sre_q),
    .dir_q(dir_q), .dbg_own(dbg_own), .rdata(bus_rdata)
  );

  gpio_ovr_padmux #(.N(N), .OSC_BASE(OSC_BASE), .OSC_W(OSC_W)) u_mux (
    .dat_q(dat_q), .pu_q(pu_q), .sre_q(sre_q), .dir_q(dir_q),
    .dbg_own(dbg_own), .dbg_oe(dbg_oe), .dbg_out(dbg_out),
    .osc_en(osc_en), .osc_oe(osc_oe), .osc_out(osc_out),
    .owned(owned), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_sre(pad_sre)
  );
endmodule

// File: rtl/gpio_ovr_chk.sv
module gpio_ovr_chk #(
  parameter int unsigned N        = 8,
  parameter int unsigned OSC_BASE = 1,
  parameter int unsigned OSC_W    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     pad_out,
  input logic [N-1:0]     pad_oe,
  input logic [N-1:0]     pad_pu,
  input logic [N-1:0]     pad_sre,
  input logic             dbg_own,
  input logic             dbg_oe,
  input logic             dbg_out,
  input logic             osc_en,
  input logic [OSC_W-1:0] osc_oe,
  input logic [OSC_W-1:0] osc_out
);
  logic [N-1:0] dbg_mask;
  assign dbg_mask = {{(N-1){1'b0}}, dbg_own};

  a_r5_slew_needs_driver: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_sre & ~pad_oe) == '0);

  a_r4_pullup_inputs_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_oe) & ~dbg_mask) == '0);

  a_r7_debug_drives_pin0: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_own |-> (pad_oe[0] == dbg_oe) && (pad_out[0] == dbg_out)
                && pad_pu[0] && !pad_sre[0]);

  a_r8_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_own |=> !dbg_own);

  a_r9_osc_claims_pins: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en |-> (pad_oe[OSC_BASE +: OSC_W] == osc_oe)
               && (pad_out[OSC_BASE +: OSC_W] == osc_out)
               && (pad_pu[OSC_BASE +: OSC_W] == '0)
               && (pad_sre[OSC_BASE +: OSC_W] == '0));
endmodule

bind gpio_ovr_port gpio_ovr_chk #(.N(N), .OSC_BASE(OSC_BASE), .OSC_W(OSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_pu(pad_pu), .pad_sre(pad_sre), .dbg_own(dbg_own),
  .dbg_oe(dbg_oe), .dbg_out(dbg_out), .osc_en(osc_en),
  .osc_oe(osc_oe), .osc_out(osc_out)
);

// File: tb/sim_gpio_ovr_port.sv
module sim_gpio_ovr_port;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, pad_pu, pad_sre;
  logic       dbg_oe = 1'b0, dbg_out = 1'b0, dbg_release = 1'b0;
  logic       dbg_own;
  logic       osc_en = 1'b0;
  logic [1:0] osc_oe = '0, osc_out = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model of the register state
  logic [7:0] m_dat, m_pu, m_sre, m_dir;
  logic       m_own;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ovr_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_sre(pad_sre),
    .dbg_oe(dbg_oe), .dbg_out(dbg_out), .dbg_release(dbg_release),
    .dbg_own(dbg_own), .osc_en(osc_en), .osc_oe(osc_oe), .osc_out(osc_out)
  );

  function automatic logic owned_bit(int i);
    if (i == 0) return m_own;
    if (i == 1 || i == 2) return osc_en;
    return 1'b0;
  endfunction

  function automatic logic [7:0] e_oe();
    logic [7:0] v;
    for (int i = 0; i < N; i++)
      if (i == 0 && m_own) v[i] = dbg_oe;
      else if ((i == 1 || i == 2) && osc_en) v[i] = osc_oe[i-1];
      else v[i] = m_dir[i];
    return v;
  endfunction

  function automatic logic [7:0] e_out();
    logic [7:0] v;
    for (int i = 0; i < N; i++)
      if (i == 0 && m_own) v[i] = dbg_out;
      else if ((i == 1 || i == 2) && osc_en) v[i] = osc_out[i-1];
      else v[i] = m_dat[i];
    return v;
  endfunction

  function automatic logic [7:0] e_pu();
    logic [7:0] v;
    for (int i = 0; i < N; i++)
      if (i == 0 && m_own) v[i] = 1'b1;
      else if (owned_bit(i)) v[i] = 1'b0;
      else v[i] = m_pu[i] & ~m_dir[i];
    return v;
  endfunction

  function automatic logic [7:0] e_sre();
    logic [7:0] v;
    for (int i = 0; i < N; i++)
      if (owned_bit(i)) v[i] = 1'b0;
      else v[i] = m_sre[i] & m_dir[i];
    return v;
  endfunction

  function automatic logic [7:0] e_rd_data();
    logic [7:0] v;
    for (int i = 0; i < N; i++)
      v[i] = (!owned_bit(i) && m_dir[i]) ? m_dat[i] : pad_in[i];
    return v;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    case (a)
      3'd0: m_dat = d;
      3'd1: m_pu  = d;
      3'd2: m_sre = d;
      3'd3: m_dir = d;
      3'd4: if (d[0]) m_own = 1'b0;
      default: ;
    endcase
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_dat = '0; m_pu = '0; m_sre = '0; m_dir = '0; m_own = 1'b1;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [7:0] v;
    chk({tag, " R2 pad_oe"},  pad_oe,  e_oe());
    chk({tag, " R2 pad_out"}, pad_out, e_out());
    chk({tag, " R4 pad_pu"},  pad_pu,  e_pu());
    chk({tag, " R5 pad_sre"}, pad_sre, e_sre());
    rd(3'd0, v); chk({tag, " R3/R10 data read"}, v, e_rd_data());
    rd(3'd1, v); chk({tag, " R4 pull read"}, v, m_pu);
    rd(3'd2, v); chk({tag, " R5 slew read"}, v, m_sre);
    rd(3'd3, v); chk({tag, " R6 dir read"}, v, m_dir);
    chk({tag, " R8 dbg_own"}, {7'd0, dbg_own}, {7'd0, m_own});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h6a11_0c5e));
    m_dat = '0; m_pu = '0; m_sre = '0; m_dir = '0; m_own = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[2:0], v);
      chk("R1 reset register", v, 8'h00);
    end
    chk("R1 reset pad_oe", pad_oe & 8'hFE, 8'h00);
    chk("R1 reset pad_pu", pad_pu & 8'hFE, 8'h00);
    chk("R1 reset pad_sre", pad_sre, 8'h00);
    chk("R1 reset dbg_own", {7'd0, dbg_own}, 8'h01);

    // R6 unused offsets read zero even with registers full
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    for (int a = 4; a < 8; a++) begin
      rd(a[2:0], v);
      chk("R6 unused offset reads zero", v, 8'h00);
    end

    // R7 debug owns pin 0 despite register bits
    wr(3'd3, 8'hFF); wr(3'd0, 8'h00);
    @(negedge clk); dbg_oe = 1'b0; dbg_out = 1'b1; #1;
    chk("R7 pin0 oe from debug", {7'd0, pad_oe[0]}, 8'h00);
    chk("R7 pin0 pu forced on", {7'd0, pad_pu[0]}, 8'h01);
    chk("R7 pin0 sre off", {7'd0, pad_sre[0]}, 8'h00);
    @(negedge clk); dbg_oe = 1'b1; #1;
    chk("R7 pin0 out from debug", {6'd0, pad_oe[0], pad_out[0]}, 8'h03);

    // R3 two-edge latency on an input pin
    wr(3'd3, 8'h00);
    @(negedge clk); pad_in = 8'hA5;
    @(negedge clk); rd(3'd0, v);
    chk("R3 not visible after one edge", v, 8'h00);
    @(negedge clk); rd(3'd0, v);
    chk("R3 visible after two edges", v, 8'hA5);

    // R8 release write with bit0 clear keeps ownership
    wr(3'd4, 8'hFE);
    chk("R8 bit0 clear keeps claim", {7'd0, dbg_own}, 8'h01);
    wr(3'd4, 8'h01);
    chk("R8 software release", {7'd0, dbg_own}, 8'h00);
    wr(3'd3, 8'h01); wr(3'd0, 8'h01);
    chk("R8 pin0 now gpio output", {6'd0, pad_oe[0], pad_out[0]}, 8'h03);

    // R9 oscillator claims pins 1,2 over full register bits
    wr(3'd3, 8'h06); wr(3'd2, 8'h06); wr(3'd0, 8'h06);
    @(negedge clk); osc_en = 1'b1; osc_oe = 2'b01; osc_out = 2'b10; #1;
    chk("R9 osc oe", {6'd0, pad_oe[2:1]}, 8'h01);
    chk("R9 osc out", {6'd0, pad_out[2:1]}, 8'h02);
    chk("R9 osc sre/pu off", {4'd0, pad_sre[2:1], pad_pu[2:1]}, 8'h00);
    @(negedge clk); pad_in = 8'h00; settle(); rd(3'd0, v);
    chk("R10 owned pins read pad level", v & 8'h06, 8'h00);

    // R8 release by debug strobe after a fresh reset
    osc_en = 1'b0;
    do_reset();
    @(negedge clk); dbg_release = 1'b1;
    @(negedge clk); dbg_release = 1'b0; m_own = 1'b0;
    chk("R8 strobe release", {7'd0, dbg_own}, 8'h00);

    // random mix
    for (int it = 0; it < 200; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 6) wr($urandom_range(0, 3), 8'($urandom));
      else if (op == 6) wr(3'd4, 8'($urandom));
      else if (op == 7) do_reset();
      else if (op == 8 && m_own) begin
        @(negedge clk); dbg_release = 1'b1;
        @(negedge clk); dbg_release = 1'b0; m_own = 1'b0;
      end
      @(negedge clk);
      pad_in  = 8'($urandom);
      osc_en  = 1'($urandom);
      osc_oe  = 2'($urandom);
      osc_out = 2'($urandom);
      dbg_oe  = 1'($urandom);
      dbg_out = 1'($urandom);
      settle();
      check_all("rand");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule